// File: doc/BRIEF.md
# Wavefront Interleaving Issue Scheduler

This block decides, clock by clock, which resident wavefront on one SIMD unit gets an issue slot. A wavefront of 64 threads runs on an 8-lane slice, so one instruction takes eight issues. Each issue carries a slice index from 0 to 7, and that index tells the datapath which group of eight threads to work on. Two interleave slots, A and B, take turns on alternate clocks. A dependent operation from one wavefront therefore always has a clock of the other wavefront between its slices, and this hides the ALU pipeline latency.

A wavefront that waits on memory is marked stalled. When its slot next comes up, the slot drops it and takes the lowest-numbered resident wavefront that is ready and not stalled. The dropped wavefront's slice position is kept, so it later resumes mid-instruction at the right slice. Launches are admitted against a fixed register budget, so the number of resident wavefronts is the budget divided by the per-wavefront demand. A launch that does not fit is refused with a busy indication. Retiring a wavefront returns its registers and its ID.

Top module: `wfs_issue_sched`

## Requirements
- R1: Each issue of a wavefront presents its current slice index, and the next issue of that wavefront presents the index plus one, wrapping from 7 back to 0 (eight issues cover 64 threads).
- R2: `issue_slot` alternates 0,1,0,1 on successive clocks after reset. With two eligible wavefronts held, the issues alternate between the two wavefronts.
- R3: When the slot whose turn it is holds no eligible wavefront and no other eligible wavefront is free, `issue_valid` is low for that clock (a bubble).
- R4: A wavefront is eligible when it is resident, its `wf_ready` bit is 1 and it is not stalled. A slot whose wavefront is not eligible is refilled with the lowest-numbered eligible wavefront that the other slot does not hold, and that wavefront issues in the same clock.
- R5: `mem_stall_valid` with an ID stalls that wavefront from the next clock. `mem_ret_valid` with an ID clears the stall. When both name the same ID in one clock, the stall wins.
- R6: A slot keeps an eligible wavefront even when a lower-numbered wavefront becomes eligible.
- R7: A wavefront that is swapped out and later swapped back in resumes at the slice after the last one it issued.
- R8: A launch is accepted (`launch_ack` high in the same clock) when an ID is free and the sum of registers in use and the demand is not above `REG_BUDGET`. The ID given is the lowest free one.
- R9: A refused launch raises `launch_busy`, and it changes neither the registers in use nor the set of resident IDs.
- R10: A retire of a resident ID frees its registers and its ID from the next clock. A retired wavefront is never issued again unless it is launched anew.
- R11: After reset no wavefront is resident, no register is in use, no issue is made and `launch_busy` is low.
- R12: A newly launched wavefront starts at slice 0 and is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wf_ready | input | NUM_WF | Per-wavefront flag that an instruction is available |
| mem_stall_valid | input | 1 | Marks a wavefront as waiting on memory |
| mem_stall_id | input | log2(NUM_WF) | Wavefront to stall |
| mem_ret_valid | input | 1 | Memory return pulse |
| mem_ret_id | input | log2(NUM_WF) | Wavefront whose stall clears |
| launch_req | input | 1 | Request to make a new wavefront resident |
| launch_regs | input | REG_W | Register demand of the new wavefront |
| launch_ack | output | 1 | Launch accepted this clock |
| launch_busy | output | 1 | Launch refused this clock (backpressure) |
| launch_id | output | log2(NUM_WF) | ID given to the accepted wavefront |
| retire_valid | input | 1 | Wavefront finished |
| retire_id | input | log2(NUM_WF) | ID of the finished wavefront |
| issue_valid | output | 1 | Issue strobe |
| issue_slot | output | 1 | Interleave slot whose turn it is (0 = A, 1 = B) |
| issue_wf | output | log2(NUM_WF) | Wavefront issued |
| issue_slice | output | log2(THREADS/LANES) | Lane slice of the issue |

## Verification
The bench drives one long interleaved sequence. In it, the slice index wraps from 7 to 0, a stalled wavefront is replaced by the lowest eligible one, and a stall and a return arrive together. A design that resets slice positions on a swap resumes at slice 0 instead of 1. A design that lets the other slot's wavefront be picked issues the same wavefront twice in a row. A design that lets the return win issues where a bubble is due. A design that preempts a held wavefront for a lower-numbered one shows the wrong ID after the stall is cleared. The budget tests fill the budget exactly, refuse one register over it and then reuse freed registers. A design that charges refused launches, or that hands out any ID other than the lowest free one, reports a wrong ID or a wrong acceptance.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } wfs_slot_e;
endpackage

// File: rtl/wfs_rst_sync.sv
module wfs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/wfs_prio.sv
module wfs_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0]         req,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wfs_budget.sv
module wfs_budget #(
  parameter int NUM_WF     = 8,
  parameter int REG_W      = 8,
  parameter int REG_BUDGET = 256
) (
  input  logic                              clk,
  input  logic                              srst_n,
  input  logic                              launch_req,
  input  logic [REG_W-1:0]                  launch_regs,
  input  logic                              retire_valid,
  input  logic [$clog2(NUM_WF)-1:0]         retire_id,
  output logic                              launch_ack,
  output logic                              launch_busy,
  output logic [$clog2(NUM_WF)-1:0]         launch_id,
  output logic [NUM_WF-1:0]                 resident_q,
  output logic [$clog2(REG_BUDGET+1)-1:0]   used_q
);
  localparam int IDW = $clog2(NUM_WF);
  localparam int UW  = $clog2(REG_BUDGET + 1);
  localparam int SW  = ((UW > REG_W) ? UW : REG_W) + 1;

  logic [REG_W-1:0]  demand_q [NUM_WF];
  logic [NUM_WF-1:0] resident_n;
  logic [UW-1:0]     used_n;
  logic              free_found;
  logic [IDW-1:0]    free_idx;
  logic [SW-1:0]     want_sum;
  logic [SW-1:0]     freed;
  logic [SW-1:0]     added;
  logic [SW-1:0]     used_calc;
  logic              fits;
  logic              ret_hit;

  wfs_prio #(.N(NUM_WF)) u_free (
    .req   (~resident_q),
    .found (free_found),
    .idx   (free_idx)
  );

  always_comb begin
    want_sum    = SW'(used_q) + SW'(launch_regs);
    fits        = (want_sum <= SW'(REG_BUDGET));
    launch_ack  = launch_req && free_found && fits;
    launch_busy = launch_req && !launch_ack;
    launch_id   = free_idx;
    ret_hit     = retire_valid && resident_q[retire_id];
  end

  always_comb begin
    resident_n = resident_q;
    freed      = '0;
    added      = '0;
    if (ret_hit) begin
      resident_n[retire_id] = 1'b0;
      freed                 = SW'(demand_q[retire_id]);
    end
    if (launch_ack) begin
      resident_n[launch_id] = 1'b1;
      added                 = SW'(launch_regs);
    end
    used_calc = SW'(used_q) - freed + added;
    used_n    = UW'(used_calc);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      resident_q <= '0;
      used_q     <= '0;
    end else begin
      resident_q <= resident_n;
      used_q     <= used_n;
    end
  end

  always_ff @(posedge clk) begin
    if (launch_ack) begin
      demand_q[launch_id] <= launch_regs;
    end
  end
endmodule

// File: rtl/wfs_stall.sv
module wfs_stall #(
  parameter int NUM_WF = 8
) (
  input  logic                      clk,
  input  logic                      srst_n,
  input  logic                      set_valid,
  input  logic [$clog2(NUM_WF)-1:0] set_id,
  input  logic                      clr_valid,
  input  logic [$clog2(NUM_WF)-1:0] clr_id,
  input  logic                      launch_ack,
  input  logic [$clog2(NUM_WF)-1:0] launch_id,
  output logic [NUM_WF-1:0]         stall_q
);
  localparam int IDW = $clog2(NUM_WF);

  logic [NUM_WF-1:0] stall_n;

  always_comb begin
    for (int i = 0; i < NUM_WF; i++) begin
      if (set_valid && set_id == IDW'(i)) begin
        stall_n[i] = 1'b1;
      end else if ((clr_valid && clr_id == IDW'(i)) ||
                   (launch_ack && launch_id == IDW'(i))) begin
        stall_n[i] = 1'b0;
      end else begin
        stall_n[i] = stall_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      stall_q <= '0;
    end else begin
      stall_q <= stall_n;
    end
  end
endmodule

// File: rtl/wfs_issue_sched.sv
module wfs_issue_sched
  import wfs_pkg::*;
#(
  parameter int NUM_WF     = 8,
  parameter int THREADS    = 64,
  parameter int LANES      = 8,
  parameter int REG_W      = 8,
  parameter int REG_BUDGET = 256
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_WF-1:0]                    wf_ready,
  input  logic                                 mem_stall_valid,
  input  logic [$clog2(NUM_WF)-1:0]            mem_stall_id,
  input  logic                                 mem_ret_valid,
  input  logic [$clog2(NUM_WF)-1:0]            mem_ret_id,
  input  logic                                 launch_req,
  input  logic [REG_W-1:0]                     launch_regs,
  output logic                                 launch_ack,
  output logic                                 launch_busy,
  output logic [$clog2(NUM_WF)-1:0]            launch_id,
  input  logic                                 retire_valid,
  input  logic [$clog2(NUM_WF)-1:0]            retire_id,
  output logic                                 issue_valid,
  output logic                                 issue_slot,
  output logic [$clog2(NUM_WF)-1:0]            issue_wf,
  output logic [$clog2(THREADS/LANES)-1:0]     issue_slice
);
  localparam int IDW    = $clog2(NUM_WF);
  localparam int SLICES = THREADS / LANES;
  localparam int SLW    = $clog2(SLICES);
  localparam int UW     = $clog2(REG_BUDGET + 1);

  logic                         srst_n;
  logic [NUM_WF-1:0]            resident_q;
  logic [NUM_WF-1:0]            stall_q;
  logic [UW-1:0]                used_q;
  wfs_slot_e                    phase_q;
  wfs_slot_e                    phase_n;
  logic [1:0]                   slot_v_q;
  logic [1:0]                   slot_v_n;
  logic [1:0][IDW-1:0]          slot_id_q;
  logic [1:0][IDW-1:0]          slot_id_n;
  logic [NUM_WF-1:0][SLW-1:0]   slice_q;
  logic [NUM_WF-1:0][SLW-1:0]   slice_n;
  logic                         cur;
  logic                         cur_v;
  logic [IDW-1:0]               cur_id;
  logic                         oth_v;
  logic [IDW-1:0]               oth_id;
  logic [NUM_WF-1:0]            elig;
  logic [NUM_WF-1:0]            excl;
  logic [NUM_WF-1:0]            cand;
  logic                         keep;
  logic                         pick_found;
  logic [IDW-1:0]               pick_idx;

  wfs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wfs_budget #(
    .NUM_WF     (NUM_WF),
    .REG_W      (REG_W),
    .REG_BUDGET (REG_BUDGET)
  ) u_budget (
    .clk          (clk),
    .srst_n       (srst_n),
    .launch_req   (launch_req),
    .launch_regs  (launch_regs),
    .retire_valid (retire_valid),
    .retire_id    (retire_id),
    .launch_ack   (launch_ack),
    .launch_busy  (launch_busy),
    .launch_id    (launch_id),
    .resident_q   (resident_q),
    .used_q       (used_q)
  );

  wfs_stall #(.NUM_WF(NUM_WF)) u_stall (
    .clk        (clk),
    .srst_n     (srst_n),
    .set_valid  (mem_stall_valid),
    .set_id     (mem_stall_id),
    .clr_valid  (mem_ret_valid),
    .clr_id     (mem_ret_id),
    .launch_ack (launch_ack),
    .launch_id  (launch_id),
    .stall_q    (stall_q)
  );

  // Slot selection for the current phase
  always_comb begin
    cur    = phase_q;
    cur_v  = slot_v_q[cur];
    cur_id = slot_id_q[cur];
    oth_v  = slot_v_q[~cur];
    oth_id = slot_id_q[~cur];
    elig   = resident_q & wf_ready & ~stall_q;
    for (int i = 0; i < NUM_WF; i++) begin
      excl[i] = oth_v && (oth_id == IDW'(i));
    end
    cand = elig & ~excl;
    keep = cur_v && elig[cur_id];
  end

  wfs_prio #(.N(NUM_WF)) u_pick (
    .req   (cand),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_comb begin
    issue_valid = keep || pick_found;
    issue_wf    = keep ? cur_id : pick_idx;
    issue_slot  = cur;
    issue_slice = slice_q[issue_wf];
  end

  // Next state
  always_comb begin
    phase_n   = (phase_q == SLOT_A) ? SLOT_B : SLOT_A;
    slot_v_n  = slot_v_q;
    slot_id_n = slot_id_q;
    slot_v_n[cur]  = issue_valid;
    slot_id_n[cur] = issue_wf;
    for (int s = 0; s < 2; s++) begin
      if (retire_valid && slot_id_n[s] == retire_id) begin
        slot_v_n[s] = 1'b0;
      end
    end
    for (int i = 0; i < NUM_WF; i++) begin
      if (launch_ack && launch_id == IDW'(i)) begin
        slice_n[i] = '0;
      end else if (issue_valid && issue_wf == IDW'(i)) begin
        slice_n[i] = (slice_q[i] == SLW'(SLICES - 1)) ? '0 : slice_q[i] + 1'b1;
      end else begin
        slice_n[i] = slice_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q   <= SLOT_A;
      slot_v_q  <= '0;
      slot_id_q <= '0;
      slice_q   <= '0;
    end else begin
      phase_q   <= phase_n;
      slot_v_q  <= slot_v_n;
      slot_id_q <= slot_id_n;
      slice_q   <= slice_n;
    end
  end
endmodule

// File: rtl/wfs_issue_checker.sv
module wfs_issue_checker #(
  parameter int NUM_WF     = 8,
  parameter int REG_BUDGET = 256
) (
  input logic                               clk,
  input logic                               srst_n,
  input logic                               issue_valid,
  input logic                               issue_slot,
  input logic [$clog2(NUM_WF)-1:0]          issue_wf,
  input logic [NUM_WF-1:0]                  wf_ready,
  input logic [NUM_WF-1:0]                  resident_q,
  input logic [NUM_WF-1:0]                  stall_q,
  input logic                               launch_ack,
  input logic                               launch_busy,
  input logic                               retire_valid,
  input logic [$clog2(REG_BUDGET+1)-1:0]    used_q
);
  p_slot_toggle_r2: assert property (@(posedge clk) disable iff (!srst_n)
    srst_n |=> issue_slot != $past(issue_slot));

  p_back_to_back_distinct_r2: assert property (@(posedge clk) disable iff (!srst_n)
    issue_valid && $past(issue_valid) |-> issue_wf != $past(issue_wf));

  p_issue_ready_r3: assert property (@(posedge clk) disable iff (!srst_n)
    issue_valid |-> wf_ready[issue_wf]);

  p_no_stalled_issue_r4: assert property (@(posedge clk) disable iff (!srst_n)
    issue_valid |-> !stall_q[issue_wf]);

  p_resident_issue_r10: assert property (@(posedge clk) disable iff (!srst_n)
    issue_valid |-> resident_q[issue_wf]);

  p_budget_bound_r8: assert property (@(posedge clk) disable iff (!srst_n)
    launch_ack |=> used_q <= ($clog2(REG_BUDGET+1))'(REG_BUDGET));

  p_refuse_exclusive_r9: assert property (@(posedge clk) disable iff (!srst_n)
    launch_busy |-> !launch_ack);

  p_refuse_no_charge_r9: assert property (@(posedge clk) disable iff (!srst_n)
    launch_busy && !retire_valid |=> used_q == $past(used_q));
endmodule

bind wfs_issue_sched wfs_issue_checker #(
  .NUM_WF     (NUM_WF),
  .REG_BUDGET (REG_BUDGET)
) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .issue_valid  (issue_valid),
  .issue_slot   (issue_slot),
  .issue_wf     (issue_wf),
  .wf_ready     (wf_ready),
  .resident_q   (resident_q),
  .stall_q      (stall_q),
  .launch_ack   (launch_ack),
  .launch_busy  (launch_busy),
  .retire_valid (retire_valid),
  .used_q       (used_q)
);

// File: tb/wfs_issue_sched_bench.sv
module wfs_issue_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP      = 36;

  typedef struct packed {
    logic [2:0] rdy;
    logic       st_v;
    logic [2:0] st_id;
    logic       rv;
    logic [2:0] rid;
    logic       tv;
    logic [2:0] tid;
    logic       ln;
    logic       ev;
    logic [2:0] eid;
    logic [2:0] esl;
    logic [3:0] req;
  } step_t;

  // rdy  stall   return  retire  ln  expected v/wf/slice  req
  localparam step_t STEPS [NSTEP] = '{
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd0, 4'd2},  // R2
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd0, 4'd2},
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd1, 4'd1},  // R1
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd1, 4'd1},
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd2, 4'd1},
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd2, 4'd1},
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd3, 4'd1},
    '{3'b011, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd3, 4'd2},
    '{3'b001, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd4, 4'd3},  // R3
    '{3'b001, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b0,3'd0,3'd0, 4'd3},
    '{3'b001, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd5, 4'd3},
    '{3'b001, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b0,3'd0,3'd0, 4'd3},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd6, 4'd4},  // R4
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd4, 4'd4},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd7, 4'd1},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd5, 4'd1},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd0, 4'd1},  // R1 wrap
    '{3'b111, 1'b1,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd6, 4'd5},  // R5 stall wf0
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd2,3'd0, 4'd4},  // R4 swap in
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd7, 4'd1},
    '{3'b111, 1'b0,3'd0, 1'b1,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd2,3'd1, 4'd5},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd0, 4'd1},
    '{3'b111, 1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd2,3'd2, 4'd6},  // R6
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd1, 4'd2},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd1, 4'd7},  // R7
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd1, 1'b0, 1'b1,3'd1,3'd2, 4'd10},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd2, 4'd7},
    '{3'b111, 1'b1,3'd2, 1'b1,3'd2, 1'b0,3'd0, 1'b0, 1'b0,3'd0,3'd0, 4'd10}, // R10
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd3, 4'd7},
    '{3'b111, 1'b0,3'd0, 1'b1,3'd2, 1'b0,3'd0, 1'b0, 1'b0,3'd0,3'd0, 4'd5},  // R5 set wins
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd4, 4'd7},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b1, 1'b1,3'd2,3'd3, 4'd5},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd5, 4'd7},
    '{3'b111, 1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd2,3'd4, 4'd6},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd0,3'd6, 4'd7},
    '{3'b111, 1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd0, 1'b0, 1'b1,3'd1,3'd0, 4'd12}  // R12
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] wf_ready;
  logic       mem_stall_valid;
  logic [2:0] mem_stall_id;
  logic       mem_ret_valid;
  logic [2:0] mem_ret_id;
  logic       launch_req;
  logic [7:0] launch_regs;
  logic       launch_ack;
  logic       launch_busy;
  logic [2:0] launch_id;
  logic       retire_valid;
  logic [2:0] retire_id;
  logic       issue_valid;
  logic       issue_slot;
  logic [2:0] issue_wf;
  logic [2:0] issue_slice;

  int  n_checks;
  int  n_fails;
  logic done;

  wfs_issue_sched u_wfs_issue_sched (
    .clk             (clk),
    .rst_n           (rst_n),
    .wf_ready        (wf_ready),
    .mem_stall_valid (mem_stall_valid),
    .mem_stall_id    (mem_stall_id),
    .mem_ret_valid   (mem_ret_valid),
    .mem_ret_id      (mem_ret_id),
    .launch_req      (launch_req),
    .launch_regs     (launch_regs),
    .launch_ack      (launch_ack),
    .launch_busy     (launch_busy),
    .launch_id       (launch_id),
    .retire_valid    (retire_valid),
    .retire_id       (retire_id),
    .issue_valid     (issue_valid),
    .issue_slot      (issue_slot),
    .issue_wf        (issue_wf),
    .issue_slice     (issue_slice)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_launch(input int regs, input int exp_ack, input int exp_id, input string tag);
    @(negedge clk);
    launch_req  = 1'b1;
    launch_regs = 8'(regs);
    #1;
    check({tag, " launch_ack"}, int'(launch_ack), exp_ack);
    check({tag, " launch_busy"}, int'(launch_busy), 1 - exp_ack);
    if (exp_ack != 0) check({tag, " launch_id"}, int'(launch_id), exp_id);
    @(posedge clk);
    #1;
    launch_req = 1'b0;
  endtask

  task automatic do_retire(input int id);
    @(negedge clk);
    retire_valid = 1'b1;
    retire_id    = 3'(id);
    @(posedge clk);
    #1;
    retire_valid = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R11: actual run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks        = 0;
    n_fails         = 0;
    rst_n           = 1'b0;
    wf_ready        = '0;
    mem_stall_valid = 1'b0;
    mem_stall_id    = '0;
    mem_ret_valid   = 1'b0;
    mem_ret_id      = '0;
    launch_req      = 1'b0;
    launch_regs     = '0;
    retire_valid    = 1'b0;
    retire_id       = '0;

    do_reset();
    // R11: nothing resident, so even with all ready there is no issue
    wf_ready = 8'hFF;
    @(negedge clk);
    #1;
    check("R11 issue_valid after reset", int'(issue_valid), 0);
    check("R11 launch_busy after reset", int'(launch_busy), 0);
    check("R11 launch_ack idle", int'(launch_ack), 0);
    wf_ready = '0;

    do_launch(8, 1, 0, "R8");
    do_launch(8, 1, 1, "R8");
    do_launch(8, 1, 2, "R8");

    // align to slot A: stop after sampling a slot B cycle
    do begin
      @(negedge clk);
      #1;
    end while (issue_slot != 1'b1);

    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      wf_ready        = {5'b0, STEPS[k].rdy};
      mem_stall_valid = STEPS[k].st_v;
      mem_stall_id    = STEPS[k].st_id;
      mem_ret_valid   = STEPS[k].rv;
      mem_ret_id      = STEPS[k].rid;
      retire_valid    = STEPS[k].tv;
      retire_id       = STEPS[k].tid;
      launch_req      = STEPS[k].ln;
      launch_regs     = 8'd8;
      #1;
      n_checks++;
      if (issue_valid !== STEPS[k].ev || issue_slot !== 1'(k % 2) ||
          (STEPS[k].ev && (issue_wf !== STEPS[k].eid || issue_slice !== STEPS[k].esl))) begin
        n_fails++;
        $display("FAIL R%0d step %0d: v/slot/wf/slice actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 STEPS[k].req, k, issue_valid, issue_slot, issue_wf, issue_slice,
                 STEPS[k].ev, k % 2, STEPS[k].eid, STEPS[k].esl);
      end
      if (STEPS[k].ln) begin
        check("R8 launch into freed id", int'(launch_id), 1);
      end
    end
    @(negedge clk);
    mem_stall_valid = 1'b0;
    mem_ret_valid   = 1'b0;
    retire_valid    = 1'b0;
    launch_req      = 1'b0;
    wf_ready        = '0;

    // Register budget, REG_BUDGET = 256
    do_reset();
    do_launch(64, 1, 0, "R8");
    do_launch(64, 1, 1, "R8");
    do_launch(64, 1, 2, "R8");
    do_launch(64, 1, 3, "R8 budget exactly full");
    do_launch(1, 0, 0, "R9 one over budget");
    do_retire(1);
    do_launch(100, 0, 0, "R9 still over budget");
    do_launch(64, 1, 1, "R9 refusals left id and budget intact");
    do_retire(0);
    do_retire(2);
    do_launch(128, 1, 0, "R10 freed registers reused");
    do_launch(1, 0, 0, "R9 full again");

    // R11: reset clears residency, first launch gets id 0 again
    do_reset();
    do_launch(255, 1, 0, "R11 state cleared by reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule